// File: doc/BRIEF.md
# Strobed Serial Register Slave

This block is a small register file that a board controller exposes to a host through four wires: a serial clock, an active-low strobe, a data line into the slave and a data line back to the host. There is no chip select around a transfer. The host shifts bits in freely and then gives a single command clock while the strobe is low. The level of the input data line on that clock says whether the bits already shifted in are a write or a read.

A write frame is 32 data bits followed by 8 address bits, then the command clock with the data line high. A read frame is 8 address bits, then the command clock with the data line low. After the strobe rises, the host gives 32 more clocks and samples the slave's output while the serial clock is high. The map holds three writable words (boot mode, pin multiplexer, display routing), a read-only switch word, a reset-request word and a read-only version constant. Writing exactly 1 to the reset word raises a reset-request output for a fixed number of system clocks.

All serial inputs are brought into the system clock domain through two-flop synchronisers. Serial clock edges are detected in that domain, so each serial clock phase must last several system clocks.

Top module: `strobe_regfile_slave`

## Requirements
- R1: Serial fields are taken MSB first on rising serial-clock edges while the strobe is high. A write commits on a rising edge with the strobe low and the data line high: the last 40 bits shifted in are used, the low 8 bits as the address and the upper 32 bits as the data.
- R2: A rising serial-clock edge with the strobe low and the data line low starts a read of the address in the last 8 bits shifted in. The 32-bit register value appears on `ser_dout` MSB first. The first bit is valid before the first rising edge after the strobe rises. Each later bit appears only after a falling serial-clock edge with the strobe high.
- R3: Addresses 0x00 (mode), 0x01 (multiplexer) and 0x02 (display routing) are read/write and read back the last value written.
- R4: Address 0x08 returns the synchronised `sw_in` value. Writes to it are ignored.
- R5: Address 0xFF returns the parameter `VERSION`. Writes to it are ignored.
- R6: Reads of any address not listed in R3, R4, R5 and R7 return 0. Writes to those addresses change no register.
- R7: Writing exactly 0x00000001 to address 0x80 raises `sys_rst_req` for exactly `PULSE_CYC` system clocks. The register then clears itself and reads back 0.
- R8: Writing any other value to address 0x80 stores the value, which reads back, and does not raise `sys_rst_req`.
- R9: After reset, mode, multiplexer and display read `MODE_INIT`, `MUX_INIT` and `DISP_INIT`, the reset word reads 0, and `sys_rst_req` and `ser_dout_en` are low.
- R10: `ser_dout_en` is high only from a read command until the 32nd falling serial-clock edge after it. Whenever it is low, `ser_dout` is 1, which matches the level of the host's pull-up.
- R11: Serial clocks taken with the strobe high never change a register, however many bits are shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host, idles low |
| ser_stb_n | input | 1 | Active-low command strobe, idles high |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data to the host |
| ser_dout_en | output | 1 | High while `ser_dout` is actively driven |
| sw_in | input | 32 | Switch inputs, synchronised inside |
| sys_rst_req | output | 1 | Reset-request pulse |

## Verification
A wrong receive-shift state appears at the next read-back: the wrong address is selected, or the data is shifted by one or more bit positions. A stuck or miscounting output bit counter appears at the ports within one read frame, either as a wrong bit value or as `ser_dout_en` staying high, or dropping, at the wrong serial clock. A bad reset-pulse counter is seen within `PULSE_CYC` clocks as a pulse of the wrong length, or as a pulse where none was requested. A register that failed to clear itself appears on the next read of address 0x80.

// File: rtl/strobe_regfile_slave.sv
module strobe_regfile_slave #(
  parameter int          DW        = 32,
  parameter int          AW        = 8,
  parameter logic [31:0] VERSION   = 32'h0001_0000,
  parameter logic [31:0] MODE_INIT = 32'h0000_0000,
  parameter logic [31:0] MUX_INIT  = 32'h0000_0000,
  parameter logic [31:0] DISP_INIT = 32'h0000_0000,
  parameter int          PULSE_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_stb_n,
  input  logic          ser_din,
  output logic          ser_dout,
  output logic          ser_dout_en,
  input  logic [DW-1:0] sw_in,
  output logic          sys_rst_req
);
  localparam int FW  = DW + AW;
  localparam int BCW = $clog2(DW);
  localparam int PCW = $clog2(PULSE_CYC + 1);
  localparam logic [AW-1:0] A_MODE = AW'(8'h00);
  localparam logic [AW-1:0] A_MUX  = AW'(8'h01);
  localparam logic [AW-1:0] A_DISP = AW'(8'h02);
  localparam logic [AW-1:0] A_SW   = AW'(8'h08);
  localparam logic [AW-1:0] A_RST  = AW'(8'h80);
  localparam logic [AW-1:0] A_VER  = AW'(8'hFF);

  logic [2:0]    s1, s2;
  logic          clk_d;
  logic [DW-1:0] sw1, sw_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 3'b010; s2 <= 3'b010; clk_d <= 1'b0;
      sw1 <= '0; sw_q <= '0;
    end else begin
      s1 <= {ser_clk, ser_stb_n, ser_din};
      s2 <= s1;
      clk_d <= s2[2];
      sw1 <= sw_in;
      sw_q <= sw1;
    end

  wire clk_rise  = s2[2] & ~clk_d;
  wire clk_fall  = ~s2[2] & clk_d;
  wire stb_s     = s2[1];
  wire din_s     = s2[0];
  wire cmd       = clk_rise & ~stb_s;
  wire wr_commit = cmd & din_s;
  wire rd_start  = cmd & ~din_s;

  logic [FW-1:0] rx_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                rx_q <= '0;
    else if (clk_rise & stb_s) rx_q <= {rx_q[FW-2:0], din_s};

  wire [AW-1:0] addr    = rx_q[AW-1:0];
  wire [DW-1:0] wr_data = rx_q[FW-1:AW];

  logic [DW-1:0] mode_q, mux_q, disp_q, rst_q;
  logic [PCW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= DW'(MODE_INIT);
      mux_q  <= DW'(MUX_INIT);
      disp_q <= DW'(DISP_INIT);
    end else if (wr_commit) begin
      if (addr == A_MODE) mode_q <= wr_data;
      if (addr == A_MUX)  mux_q  <= wr_data;
      if (addr == A_DISP) disp_q <= wr_data;
    end

  wire rst_hit = wr_commit && addr == A_RST;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q <= '0;
      pcnt  <= '0;
    end else begin
      if (rst_hit)                    rst_q <= wr_data;
      else if (pcnt == PCW'(1))       rst_q <= '0;
      if (rst_hit && wr_data == DW'(1)) pcnt <= PCW'(PULSE_CYC);
      else if (pcnt != '0)            pcnt <= pcnt - PCW'(1);
    end

  assign sys_rst_req = pcnt != '0;

  logic [DW-1:0] rd_data;
  always_comb
    case (addr)
      A_MODE:  rd_data = mode_q;
      A_MUX:   rd_data = mux_q;
      A_DISP:  rd_data = disp_q;
      A_SW:    rd_data = sw_q;
      A_RST:   rd_data = rst_q;
      A_VER:   rd_data = DW'(VERSION);
      default: rd_data = '0;
    endcase

  logic [DW-1:0]  out_q;
  logic           rd_act;
  logic [BCW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q  <= '0;
      rd_act <= 1'b0;
      bcnt   <= '0;
    end else if (rd_start) begin
      out_q  <= rd_data;
      rd_act <= 1'b1;
      bcnt   <= '0;
    end else if (rd_act && clk_fall && stb_s) begin
      out_q <= {out_q[DW-2:0], 1'b0};
      bcnt  <= bcnt + BCW'(1);
      if (bcnt == BCW'(DW - 1)) rd_act <= 1'b0;
    end

  assign ser_dout_en = rd_act;
  assign ser_dout    = rd_act ? out_q[DW-1] : 1'b1;
endmodule

module strobe_regfile_slave_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_dout,
  input logic          ser_dout_en,
  input logic          sys_rst_req,
  input logic          clk_fall,
  input logic          wr_commit,
  input logic [DW-1:0] mode_q,
  input logic [DW-1:0] mux_q,
  input logic [DW-1:0] disp_q,
  input logic [DW-1:0] rst_q
);
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dout_en |-> ser_dout);
  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_dout_en && $past(ser_dout_en) && !$past(clk_fall) |-> $stable(ser_dout));
  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(wr_commit));
  // R7
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) && !$past(wr_commit) |-> rst_q == '0);
  // R11
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_commit) |-> $stable(mode_q) && $stable(mux_q) && $stable(disp_q));
endmodule

bind strobe_regfile_slave strobe_regfile_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
  .sys_rst_req(sys_rst_req), .clk_fall(clk_fall), .wr_commit(wr_commit),
  .mode_q(mode_q), .mux_q(mux_q), .disp_q(disp_q), .rst_q(rst_q)
);

// File: tb/sim_strobe_regfile_slave.sv
module sim_strobe_regfile_slave;
  localparam logic [31:0] VER  = 32'h5A01_0007;
  localparam logic [31:0] MODI = 32'h0000_0040;
  localparam logic [31:0] MUXI = 32'h0000_4000;
  localparam logic [31:0] DISI = 32'h0000_0007;
  localparam int PULSE = 12;
  localparam int HALF  = 5;

  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_stb_n = 1, ser_din = 0;
  logic ser_dout, ser_dout_en, sys_rst_req;
  logic [31:0] sw_in = 32'hC3A5_0F12;

  always #4 clk = ~clk;

  strobe_regfile_slave #(.VERSION(VER), .MODE_INIT(MODI), .MUX_INIT(MUXI),
    .DISP_INIT(DISI), .PULSE_CYC(PULSE)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_stb_n(ser_stb_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
    .sw_in(sw_in), .sys_rst_req(sys_rst_req));

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_mode = MODI, m_mux = MUXI, m_disp = DISI, m_rst = 0;
  bit pulse_ok = 0;
  int hi_cnt = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_in(logic b);
    ser_din = b; hold(2);
    ser_clk = 1; hold(HALF);
    ser_clk = 0; hold(HALF);
  endtask

  task automatic command(logic d);
    ser_din = d; ser_stb_n = 0; hold(2);
    ser_clk = 1; hold(HALF);
    ser_clk = 0; hold(HALF);
    ser_stb_n = 1; ser_din = 0; hold(HALF);
  endtask

  function automatic logic [31:0] model_rd(logic [7:0] a);
    case (a)
      8'h00: return m_mode;
      8'h01: return m_mux;
      8'h02: return m_disp;
      8'h08: return sw_in;
      8'h80: return m_rst;
      8'hFF: return VER;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    for (int i = 31; i >= 0; i--) bit_in(d[i]);
    for (int i = 7; i >= 0; i--) bit_in(a[i]);
    case (a)
      8'h00: m_mode = d;
      8'h01: m_mux = d;
      8'h02: m_disp = d;
      8'h80: begin
        if (d == 32'h1) begin pulse_ok = 1; m_rst = 0; end
        else m_rst = d;
      end
      default: ;
    endcase
    command(1'b1);
  endtask

  task automatic rd(string req, logic [7:0] a);
    logic [31:0] got = 0;
    for (int i = 7; i >= 0; i--) bit_in(a[i]);
    command(1'b0);
    chk({req, " R10 en during read"}, 32'(ser_dout_en), 32'h1);
    for (int i = 0; i < 32; i++) begin
      ser_clk = 1; hold(2);
      got = {got[30:0], ser_dout};
      hold(HALF - 2);
      ser_clk = 0; hold(HALF);
    end
    hold(HALF);
    chk({req, " R10 en after read"}, 32'(ser_dout_en), 32'h0);
    chk(req, got, model_rd(a));
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (!ser_dout_en && ser_dout !== 1'b1) begin
      errors++; $display("FAIL R10 idle dout actual=%b expected=1", ser_dout);
    end
    if (sys_rst_req) begin
      hi_cnt++;
      if (!pulse_ok) begin
        errors++; $display("FAIL R8 unexpected reset pulse actual=1 expected=0");
      end
    end else if (hi_cnt != 0) begin
      chk("R7 pulse length", 32'(hi_cnt), 32'(PULSE));
      hi_cnt = 0; pulse_ok = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    hold(3);
    chk("R9 rst_req", 32'(sys_rst_req), 32'h0);
    chk("R9 dout_en", 32'(ser_dout_en), 32'h0);
    rst_n = 1; hold(4);
    rd("R9 mode", 8'h00);
    rd("R9 mux", 8'h01);
    rd("R9 disp", 8'h02);
    rd("R9 rst word", 8'h80);
    rd("R5 version", 8'hFF);
    wr(8'h01, 32'hA5A5_5A5A); rd("R3 mux", 8'h01);
    wr(8'h00, 32'hFFFF_FFFF); rd("R1 R3 mode ones", 8'h00);
    wr(8'h02, 32'h8000_0001); rd("R1 R3 disp ends", 8'h02);
    wr(8'h00, 32'h0000_0000); rd("R3 mode zero", 8'h00);
    wr(8'h08, 32'h1234_5678); rd("R4 switch", 8'h08);
    sw_in = 32'h0F0F_8001; hold(5); rd("R4 switch change", 8'h08);
    wr(8'hFF, 32'hDEAD_BEEF); rd("R5 version after write", 8'hFF);
    wr(8'h33, 32'h1111_2222); rd("R6 unmapped", 8'h33);
    rd("R6 mux kept", 8'h01);
    for (int i = 31; i >= 0; i--) bit_in(i[0]);
    for (int i = 7; i >= 0; i--) bit_in(1'b0);
    hold(4);
    rd("R11 mode unchanged", 8'h00);
    wr(8'h80, 32'h0000_0005); hold(PULSE + 4);
    chk("R8 no pulse", 32'(sys_rst_req), 32'h0);
    rd("R8 rst word stored", 8'h80);
    wr(8'h80, 32'h0000_0001); hold(PULSE + 4);
    chk("R7 pulse seen and done", 32'(pulse_ok), 32'h0);
    rd("R7 self clear", 8'h80);
    rd("R2 version again", 8'hFF);
    finish_run();
  end
endmodule